// File: doc/BRIEF.md
# Burst Bus Initiator Sequencer

This block is the initiator side of a shared parallel bus that uses active-low strobes and a multiplexed 32-bit address/data path. The local logic places a request made of a start address, a command code and a word count. When the arbiter's grant input is low, the sequencer runs one address phase and then a series of data phases. Write words are taken from the local side one at a time. Read words are handed back one at a time.

Pacing is done with the initiator-ready strobe against the target's ready strobe. The frame strobe is released so that the final data phase runs with frame high. A transaction can also end early, in two ways. If no device claims the access within a fixed number of clocks, the cycle ends as a master abort. If the target asks to stop, the frame strobe is released at once. In every case the bus spends one turnaround clock idle. During that clock the block reports a completion status and the number of words that did not move, so the local side can decide whether to retry.

Top module: `burst_initiator`

## Requirements
- R1: After reset `frame_n` and `irdy_n` are high, `ad_oe` is low, and `busy` and `done` are low.
- R2: A transaction starts only on a clock where `req` is high, `gnt_n` is low and `req_count` is nonzero. A request with a zero count is ignored, and a request waits while `gnt_n` is high.
- R3: The address phase lasts one clock. During it `frame_n` is low, `irdy_n` is high, `ad_oe` is high, `ad_out` carries `req_addr` and `cbe_n` carries `req_cmd`.
- R4: During data phases `irdy_n` is low and `cbe_n` is 4'b0000. Bit 0 of the command selects the direction (1 = write). On a write, `ad_out` carries the local word with `ad_oe` high. On a read, `ad_oe` is low and `ad_in` is returned on `rd_data` with `rd_valid`.
- R5: A word moves only on a clock edge where `irdy_n`, `trdy_n` and `devsel_n` are all low. On other edges the current word is held, and `wr_take` and `rd_valid` stay low.
- R6: `frame_n` stays low through every data phase except the final one, which runs with `frame_n` high.
- R7: If `devsel_n` is not sampled low at any of the DEVSEL_WAIT (default 5) edges after the address phase, the transaction ends with status 2'b10 and `remain` equal to the requested count. A claim at the fifth edge still completes.
- R8: When `stop_n` is sampled low with `devsel_n` low in a data phase, both `frame_n` and `irdy_n` are high on the next clock. The status is 2'b01 and `remain` counts the words not moved. A word that moves on the same edge as the stop counts as moved.
- R9: Every transaction ends with one turnaround clock. In that clock `frame_n` and `irdy_n` are high, `ad_oe` is low, and `done` is high with `status` and `remain` valid. A normal completion gives status 2'b00 and remain 0. `busy` is low on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Local transaction request (level) |
| req_addr | input | 32 | Start address |
| req_cmd | input | 4 | Command code; bit 0 = write |
| req_count | input | 8 | Number of words |
| wr_data | input | 32 | Current write word from local side |
| wr_take | output | 1 | Current write word consumed this edge |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | Read word accepted this edge |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Turnaround clock; status valid |
| status | output | 2 | 00 done, 01 target stop, 10 master abort |
| remain | output | 8 | Words not transferred |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n | output | 1 | Frame strobe, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| cbe_n | output | 4 | Command / byte enables |
| ad_out | output | 32 | Address/data driven value |
| ad_oe | output | 1 | Address/data output enable |
| ad_in | input | 32 | Address/data sampled value |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| devsel_n | input | 1 | Device claimed, active low |

## Verification
The assertions assume a well-behaved target. It drives `trdy_n` and `stop_n` low only while it also holds `devsel_n` low, and it returns all three to high once the initiator releases `irdy_n`. They also assume the arbiter leaves `gnt_n` stable around an idle request. The bench keeps to these rules through a single target model. The model waits for an address phase before driving anything. It asserts ready or stop only after it has claimed the access, and it releases every response line as soon as it sees the turnaround clock.

// File: rtl/burst_initiator.sv
module burst_initiator #(
  parameter int DATA_W      = 32,
  parameter int CMD_W       = 4,
  parameter int CNT_W       = 8,
  parameter int DEVSEL_WAIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_take,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [CNT_W-1:0]  remain,
  input  logic              gnt_n,
  output logic              frame_n,
  output logic              irdy_n,
  output logic [CMD_W-1:0]  cbe_n,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  input  logic              trdy_n,
  input  logic              stop_n,
  input  logic              devsel_n
);

  localparam int TW = $clog2(DEVSEL_WAIT + 1);
  localparam logic [TW-1:0] WAIT_LAST = TW'(DEVSEL_WAIT - 1);
  localparam logic [1:0] ST_OK = 2'b00, ST_STOP = 2'b01, ST_ABORT = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_TURN} state_t;

  state_t            st;
  logic [DATA_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [CNT_W-1:0]  left_q;
  logic [1:0]        status_q;
  logic              seen_q;
  logic [TW-1:0]     wait_q;

  wire in_data   = (st == S_DATA);
  wire is_wr     = cmd_q[0];
  wire last      = (left_q == CNT_W'(1));
  wire start     = (st == S_IDLE) && req && !gnt_n && (req_count != '0);
  wire xfer      = in_data && !trdy_n && !devsel_n;
  wire stop_hit  = in_data && !stop_n && !devsel_n;
  wire abort_hit = in_data && !seen_q && devsel_n && (wait_q == WAIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      cmd_q    <= '0;
      left_q   <= '0;
      status_q <= ST_OK;
      seen_q   <= 1'b0;
      wait_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          addr_q <= req_addr;
          cmd_q  <= req_cmd;
          left_q <= req_count;
          st     <= S_ADDR;
        end
        S_ADDR: begin
          seen_q <= 1'b0;
          wait_q <= '0;
          st     <= S_DATA;
        end
        S_DATA: begin
          if (!devsel_n) seen_q <= 1'b1;
          else if (!seen_q && wait_q != WAIT_LAST) wait_q <= wait_q + 1'b1;
          if (xfer) left_q <= left_q - 1'b1;
          if (abort_hit) begin
            status_q <= ST_ABORT;
            st       <= S_TURN;
          end else if (stop_hit) begin
            status_q <= ST_STOP;
            st       <= S_TURN;
          end else if (xfer && last) begin
            status_q <= ST_OK;
            st       <= S_TURN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_TURN);
  assign status   = status_q;
  assign remain   = left_q;
  assign frame_n  = !((st == S_ADDR) || (in_data && !last));
  assign irdy_n   = !in_data;
  assign ad_oe    = (st == S_ADDR) || (in_data && is_wr);
  assign ad_out   = (st == S_ADDR) ? addr_q : wr_data;
  assign cbe_n    = (st == S_ADDR) ? cmd_q : (in_data ? '0 : '1);
  assign wr_take  = xfer && is_wr;
  assign rd_valid = xfer && !is_wr;
  assign rd_data  = ad_in;

  AST_NO_START_WITHOUT_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && gnt_n) |=> frame_n);  // R2
  AST_ADDR_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> (irdy_n ##1 !irdy_n));  // R3
  AST_WAIT_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && trdy_n && stop_n && !devsel_n) |=> (!irdy_n && $stable(remain)));  // R5
  AST_MORE_AFTER_FRAME_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !frame_n && !trdy_n && !devsel_n && stop_n) |=> !irdy_n);  // R6
  AST_FINAL_PHASE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && frame_n && !trdy_n && !devsel_n) |=> (irdy_n && done));  // R6
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !stop_n && !devsel_n) |=> (frame_n && irdy_n && status == ST_STOP));  // R8
  AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (frame_n && irdy_n && !ad_oe));  // R9
  AST_TURN_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);  // R9
  AST_ABORT_FULL_REMAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !devsel_n) |=> (status != ST_ABORT || !done));  // R7

endmodule

// File: tb/burst_initiator_test.sv
module burst_initiator_test;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        req = 0, gnt_n = 1;
  logic [31:0] req_addr = 0, wr_data, rd_data, ad_out, ad_in = 0;
  logic [3:0]  req_cmd = 0, cbe_n;
  logic [7:0]  req_count = 0, remain;
  logic        wr_take, rd_valid, busy, done, frame_n, irdy_n, ad_oe;
  logic [1:0]  status;
  logic        trdy_n = 1, stop_n = 1, devsel_n = 1;

  burst_initiator uut (.clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_count(req_count), .wr_data(wr_data), .wr_take(wr_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .status(status),
    .remain(remain), .gnt_n(gnt_n), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .trdy_n(trdy_n), .stop_n(stop_n),
    .devsel_n(devsel_n));

  int total = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // local side
  int wr_idx = 0, w0 = 0, rd_n = 0;
  logic [31:0] wbase = 0;
  logic [31:0] rd_got [0:63];
  assign wr_data = wbase + 32'(wr_idx - w0);
  always @(posedge clk) begin
    if (wr_take) wr_idx <= wr_idx + 1;
    if (rd_valid && rd_n < 64) begin
      rd_got[rd_n] <= rd_data;
      rd_n <= rd_n + 1;
    end
  end

  // target model
  int dev_lat = 1, tgt_wait = 0, stop_word = -1;
  bit stop_data = 0, active = 0, last_hi = 0;
  int ph = 0, wcnt = 0, words = 0, hi_cnt = 0, a_cyc = 0, s_cyc = 0, oe_bad = 0, be_bad = 0;
  logic [31:0] t_addr = 0;
  logic [3:0]  t_cmd = 0;
  bit t_oe = 0;
  logic [31:0] tmem [0:63];

  always @(negedge clk) begin
    if (!rst_n) begin
      active = 0; devsel_n = 1; trdy_n = 1; stop_n = 1;
    end else if (!frame_n && irdy_n) begin
      active = 1; ph = 0; wcnt = 0;
      t_addr = ad_out; t_cmd = cbe_n; t_oe = ad_oe; a_cyc = cyc;
      devsel_n = 1; trdy_n = 1; stop_n = 1;
    end else if (active && !irdy_n) begin
      bit dsel, sthit, tr;
      ph++;
      dsel  = (ph >= dev_lat);
      sthit = dsel && stop_word >= 0 && words == stop_word;
      tr    = dsel && (sthit ? stop_data : (wcnt >= tgt_wait));
      if (ad_oe !== t_cmd[0]) oe_bad++;
      if (cbe_n !== 4'b0000) be_bad++;
      devsel_n = !dsel; trdy_n = !tr; stop_n = !sthit;
      ad_in = 32'hA000_0000 + 32'(words);
      if (sthit) s_cyc = cyc;
      if (tr) begin
        if (words < 64) tmem[words] = ad_out;
        hi_cnt += int'(frame_n);
        last_hi = frame_n;
        words++; wcnt = 0;
      end else wcnt++;
    end else begin
      active = 0; devsel_n = 1; trdy_n = 1; stop_n = 1;
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  int d_cyc;
  bit d_frame, d_irdy, d_oe, b_after;
  logic [1:0] d_status;
  logic [7:0] d_remain;
  int r0;

  task automatic run(input logic [31:0] addr, input logic [3:0] cmd, input logic [7:0] cnt,
                     input int lat, input int tw, input int sw, input bit sd);
    bit seen;
    dev_lat = lat; tgt_wait = tw; stop_word = sw; stop_data = sd;
    words = 0; hi_cnt = 0; last_hi = 0; oe_bad = 0; be_bad = 0;
    @(negedge clk);
    w0 = wr_idx; r0 = rd_n; wbase = addr ^ 32'h5A5A_0000;
    req_addr = addr; req_cmd = cmd; req_count = cnt; req = 1; gnt_n = 0;
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      seen = busy;
    end
    req = 0;
    if (!seen) chk("R2", "start timeout", 0, 1);
    seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1; d_cyc = cyc; d_frame = frame_n; d_irdy = irdy_n; d_oe = ad_oe;
        d_status = status; d_remain = remain;
      end
    end
    if (!seen) chk("R9", "done timeout", 0, 1);
    @(negedge clk);
    b_after = busy;
  endtask

  task automatic t_reset;
    chk("R1", "frame_n", frame_n, 1);
    chk("R1", "irdy_n", irdy_n, 1);
    chk("R1", "ad_oe", ad_oe, 0);
    chk("R1", "busy/done", {busy, done}, 0);
  endtask

  task automatic t_gating;
    bit moved = 0;
    @(negedge clk);
    req_count = 4; req = 1; gnt_n = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!frame_n || busy) moved = 1;
    end
    chk("R2", "start without grant", moved, 0);
    req = 0;
    @(negedge clk);
    req_count = 0; req = 1; gnt_n = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!frame_n || busy) moved = 1;
    end
    chk("R2", "zero count started", moved, 0);
    req = 0;
  endtask

  task automatic t_single_write;
    run(32'h1000_0040, 4'b0111, 1, 1, 0, -1, 0);
    chk("R3", "address", t_addr, 32'h1000_0040);
    chk("R3", "command", t_cmd, 4'b0111);
    chk("R3", "ad_oe in address", t_oe, 1);
    chk("R4", "write word", tmem[0], 32'h1000_0040 ^ 32'h5A5A_0000);
    chk("R6", "single phase frame high", {hi_cnt[7:0], 7'd0, last_hi}, {8'd1, 8'd1});
    chk("R9", "status/remain", {d_status, d_remain}, {2'b00, 8'd0});
    chk("R9", "turnaround strobes", {d_frame, d_irdy, d_oe}, 3'b110);
    chk("R9", "busy after", b_after, 0);
  endtask

  task automatic t_burst_write;
    logic [31:0] b = 32'h2000_0100 ^ 32'h5A5A_0000;
    run(32'h2000_0100, 4'b0111, 4, 2, 2, -1, 0);
    chk("R5", "words moved", words, 4);
    for (int k = 0; k < 4; k++) chk("R5", "held write word", tmem[k], b + 32'(k));
    chk("R6", "frame high only at last", {hi_cnt[7:0], 7'd0, last_hi}, {8'd1, 8'd1});
    chk("R4", "oe/be in data", {oe_bad[7:0], be_bad[7:0]}, 0);
    chk("R9", "status/remain", {d_status, d_remain}, {2'b00, 8'd0});
  endtask

  task automatic t_burst_read;
    run(32'h3000_0000, 4'b0110, 5, 1, 1, -1, 0);
    chk("R4", "oe/be in read data", {oe_bad[7:0], be_bad[7:0]}, 0);
    chk("R5", "reads delivered", rd_n - r0, 5);
    for (int k = 0; k < 5; k++) chk("R4", "read word", rd_got[r0 + k], 32'hA000_0000 + 32'(k));
    chk("R6", "frame high only at last", {hi_cnt[7:0], 7'd0, last_hi}, {8'd1, 8'd1});
    chk("R9", "status", d_status, 2'b00);
  endtask

  task automatic t_abort;
    run(32'h4000_0000, 4'b0111, 3, 99, 0, -1, 0);
    chk("R7", "status/remain", {d_status, d_remain}, {2'b10, 8'd3});
    chk("R7", "abort clocks after address", d_cyc - a_cyc, 6);
    chk("R7", "no words", words, 0);
    chk("R9", "turnaround strobes", {d_frame, d_irdy, d_oe}, 3'b110);
  endtask

  task automatic t_late_claim;
    run(32'h5000_0000, 4'b0110, 2, 5, 0, -1, 0);
    chk("R7", "claim at fifth edge completes", {d_status, d_remain}, {2'b00, 8'd0});
    chk("R7", "words", words, 2);
  endtask

  task automatic t_stop_nodata;
    run(32'h6000_0000, 4'b0111, 4, 1, 0, 2, 0);
    chk("R8", "status/remain", {d_status, d_remain}, {2'b01, 8'd2});
    chk("R8", "words", words, 2);
    chk("R8", "release next clock", d_cyc - s_cyc, 1);
    chk("R9", "turnaround strobes", {d_frame, d_irdy}, 2'b11);
  endtask

  task automatic t_stop_data;
    run(32'h7000_0000, 4'b0110, 3, 1, 0, 1, 1);
    chk("R8", "stop with data remain", {d_status, d_remain}, {2'b01, 8'd1});
    chk("R8", "words", words, 2);
    chk("R8", "reads", rd_n - r0, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gating();
    t_single_write();
    t_burst_write();
    t_burst_read();
    t_abort();
    t_late_claim();
    t_stop_nodata();
    t_stop_data();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule